// File: doc/BRIEF.md
# Indexed Register Access Bridge

The bridge connects a narrow host window of eight byte ports to a 256-byte internal register space of a bus controller. The host never addresses the internal space directly. It first writes a pointer through one port, then moves data through data ports that act on the register the pointer selects. Two of the data ports step the pointer forward after each access, so a run of consecutive registers costs one pointer load followed by one access per byte. The host can read the pointer back, and it can pulse a reset strobe into the controller.

A small register-array model stands in for the controller. It holds 256 bytes. After a reset strobe, it flags itself busy for a fixed number of cycles through bit 7 of the CPU interface register at internal address 0x00. The host polls that bit until it clears. Message object n, for n from 0 to 14, begins at internal address (n+1)*16. A package function computes these base addresses.

Top module: `idx_reg_bridge`

## Requirements
- R1: After reset the pointer is 0x00, `host_rdata` is 0x00 and `ctrl_rst` is low.
- R2: A write to offset 1 loads `host_wdata` into the pointer. A read from offset 5 returns the pointer value.
- R3: A read from offset 2 returns the byte at the pointer and leaves the pointer unchanged.
- R4: A read from offset 3 returns the byte at the pointer, then adds one to the pointer.
- R5: A write to offset 6 stores `host_wdata` at the pointer and leaves the pointer unchanged.
- R6: A write to offset 7 stores `host_wdata` at the pointer, then adds one to the pointer.
- R7: The pointer is 8 bits wide, and an increment from 0xFF gives 0x00.
- R8: A write to offset 0 raises `ctrl_rst` for exactly the one cycle after the access, whatever the value of `host_wdata`.
- R9: For RST_CYCLES cycles after the strobe, a read of internal address 0x00 returns the stored byte with bit 7 forced to 1. After that it returns the stored byte unchanged.
- R10: Any access to offset 4, a write to offset 2, 3 or 5, and a read from offset 0, 1, 6 or 7 change neither the pointer nor the register space. Each such read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access valid in this cycle |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_ofs | input | 3 | Port offset within the 8-byte window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data; changes only on host reads |
| ctrl_rst | output | 1 | One-cycle reset strobe to the controller |

## Verification
Every host access is a single cycle. Its result appears at the clock edge that samples it: `host_rdata`, the pointer and the register byte all update at that edge. The reset strobe is high during the following cycle, and the busy window starts one edge later. The bench drives each access on a falling edge and reads `host_rdata` and `ctrl_rst` on the next falling edge, half a cycle after the edge that updates them. It confirms pointer moves by reading back offset 5 after each scenario. For the busy flag it requires bit 7 to be set on the first poll and to clear within a bounded number of polls.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int PTR_W  = 8;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PORT_RESET   = 3'd0,
    PORT_ADDR    = 3'd1,
    PORT_RD      = 3'd2,
    PORT_RD_INC  = 3'd3,
    PORT_SPARE   = 3'd4,
    PORT_ADDR_RD = 3'd5,
    PORT_WR      = 3'd6,
    PORT_WR_INC  = 3'd7
  } port_e;

  // pointer step, wraps at the top of the space
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + {{(PTR_W-1){1'b0}}, 1'b1};
  endfunction

  // first address of message object n
  function automatic logic [PTR_W-1:0] obj_base(input int unsigned n);
    return PTR_W'((n + 1) * 16);
  endfunction
endpackage

// File: rtl/port_decode.sv
module port_decode
  import bridge_pkg::*;
(
  input  logic       sel,
  input  logic       we,
  input  logic [2:0] ofs,
  output logic       rst_ev,
  output logic       load_ev,
  output logic       rd_data_ev,
  output logic       rd_ptr_ev,
  output logic       rd_zero_ev,
  output logic       wr_data_ev,
  output logic       inc_ev
);
  port_e port;
  assign port = port_e'(ofs);

  always_comb begin
    rst_ev     = 1'b0;
    load_ev    = 1'b0;
    rd_data_ev = 1'b0;
    rd_ptr_ev  = 1'b0;
    rd_zero_ev = 1'b0;
    wr_data_ev = 1'b0;
    inc_ev     = 1'b0;
    if (sel) begin
      if (we) begin
        unique case (port)
          PORT_RESET:  rst_ev = 1'b1;
          PORT_ADDR:   load_ev = 1'b1;
          PORT_WR:     wr_data_ev = 1'b1;
          PORT_WR_INC: begin wr_data_ev = 1'b1; inc_ev = 1'b1; end
          default:     ;
        endcase
      end else begin
        unique case (port)
          PORT_RD:      rd_data_ev = 1'b1;
          PORT_RD_INC:  begin rd_data_ev = 1'b1; inc_ev = 1'b1; end
          PORT_ADDR_RD: rd_ptr_ev = 1'b1;
          default:      rd_zero_ev = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/addr_ptr.sv
module addr_ptr
  import bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic             inc_ev,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (load_ev) ptr <= load_val;
    else if (inc_ev)  ptr <= ptr_step(ptr);
  end

  // R4
  ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ev && !load_ev) |=> ptr == PTR_W'($past(ptr) + 1));
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_ev && !load_ev) |=> $stable(ptr));
  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> ptr == $past(load_val));
endmodule

// File: rtl/reg_model.sv
module reg_model
  import bridge_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter logic [PTR_W-1:0] STATUS_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_strobe,
  input  logic [PTR_W-1:0]  addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_INIT = CW'(RST_CYCLES);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     busy_cnt;
  logic              busy;

  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= BUSY_INIT;
    else if (rst_strobe) busy_cnt <= BUSY_INIT;
    else if (busy)       busy_cnt <= busy_cnt - 1'b1;
  end

  always_comb begin
    rdata = mem[addr];
    if (addr == STATUS_ADDR && busy) rdata[DATA_W-1] = 1'b1;
  end

  // R9
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_strobe |=> busy);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(rst_strobe));
endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
  import bridge_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_we,
  input  logic [2:0] host_ofs,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       ctrl_rst
);
  logic rst_ev, load_ev, rd_data_ev, rd_ptr_ev, rd_zero_ev, wr_data_ev, inc_ev;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] model_rdata;

  port_decode u_dec (
    .sel(host_sel), .we(host_we), .ofs(host_ofs),
    .rst_ev(rst_ev), .load_ev(load_ev), .rd_data_ev(rd_data_ev),
    .rd_ptr_ev(rd_ptr_ev), .rd_zero_ev(rd_zero_ev),
    .wr_data_ev(wr_data_ev), .inc_ev(inc_ev)
  );

  addr_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .inc_ev(inc_ev),
    .load_val(host_wdata), .ptr(ptr)
  );

  reg_model #(.RST_CYCLES(RST_CYCLES)) u_model (
    .clk(clk), .rst_n(rst_n), .rst_strobe(ctrl_rst), .addr(ptr),
    .wr_en(wr_data_ev), .wdata(host_wdata), .rdata(model_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_rst   <= 1'b0;
      host_rdata <= '0;
    end else begin
      ctrl_rst <= rst_ev;
      if (rd_data_ev)      host_rdata <= model_rdata;
      else if (rd_ptr_ev)  host_rdata <= ptr;
      else if (rd_zero_ev) host_rdata <= '0;
    end
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ev |=> ctrl_rst);
  // R8
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ev |=> !ctrl_rst);
  // R10
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero_ev |=> host_rdata == '0);
  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_ev, load_ev, rd_data_ev, rd_ptr_ev, rd_zero_ev, wr_data_ev}));
endmodule

// File: tb/test_idx_reg_bridge.sv
module test_idx_reg_bridge;
  localparam int RST_CYCLES = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_ofs = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       ctrl_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  idx_reg_bridge #(.RST_CYCLES(RST_CYCLES)) i_idx_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ctrl_rst(ctrl_rst)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one access; result sampled half a cycle after its edge
  task automatic acc(input logic we, input logic [2:0] ofs, input logic [7:0] wd,
                     output logic [7:0] rd);
    @(negedge clk);
    host_sel = 1'b1; host_we = we; host_ofs = ofs; host_wdata = wd;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
    rd = host_rdata;
  endtask

  task automatic wr(input logic [2:0] ofs, input logic [7:0] wd);
    logic [7:0] d;
    acc(1'b1, ofs, wd, d);
  endtask

  task automatic rd(input logic [2:0] ofs, output logic [7:0] d);
    acc(1'b0, ofs, 8'h00, d);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R1 rdata", host_rdata, 8'h00);
    check("R1 ctrl_rst", {7'd0, ctrl_rst}, 8'h00);
    rd(3'd5, d); check("R1 pointer", d, 8'h00);
  endtask

  task automatic t_load();
    logic [7:0] d;
    wr(3'd1, 8'h3C); rd(3'd5, d); check("R2 load/readback", d, 8'h3C);
    wr(3'd1, 8'hC3); rd(3'd5, d); check("R2 reload", d, 8'hC3);
  endtask

  task automatic t_plain();
    logic [7:0] d;
    wr(3'd1, 8'h20); wr(3'd6, 8'hA5);
    rd(3'd5, d); check("R5 pointer held", d, 8'h20);
    rd(3'd2, d); check("R3 data", d, 8'hA5);
    rd(3'd2, d); check("R3 repeat", d, 8'hA5);
    rd(3'd5, d); check("R3 pointer held", d, 8'h20);
  endtask

  task automatic t_burst();
    logic [7:0] d;
    wr(3'd1, bridge_pkg::obj_base(2));
    for (int i = 0; i < 3; i++) wr(3'd7, 8'h11 * (i + 1));
    rd(3'd5, d); check("R6 pointer advanced", d, 8'h33);
    wr(3'd1, 8'h30);
    for (int i = 0; i < 3; i++) begin
      rd(3'd3, d); check("R4 burst data", d, 8'h11 * (i + 1));
    end
    rd(3'd5, d); check("R4 pointer advanced", d, 8'h33);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wr(3'd1, 8'hFF); wr(3'd7, 8'h77);
    rd(3'd5, d); check("R7 write wrap", d, 8'h00);
    wr(3'd1, 8'hFF); rd(3'd3, d); check("R7 data at FF", d, 8'h77);
    rd(3'd5, d); check("R7 read wrap", d, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr(3'd1, 8'h40); wr(3'd6, 8'h5A);
    wr(3'd2, 8'h99); wr(3'd3, 8'h99); wr(3'd4, 8'h99); wr(3'd5, 8'h99);
    rd(3'd5, d); check("R10 pointer after bad writes", d, 8'h40);
    rd(3'd2, d); check("R10 data after bad writes", d, 8'h5A);
    rd(3'd0, d); check("R10 read ofs0", d, 8'h00);
    rd(3'd1, d); check("R10 read ofs1", d, 8'h00);
    rd(3'd4, d); check("R10 read ofs4", d, 8'h00);
    rd(3'd6, d); check("R10 read ofs6", d, 8'h00);
    rd(3'd7, d); check("R10 read ofs7", d, 8'h00);
    rd(3'd5, d); check("R10 pointer after bad reads", d, 8'h40);
  endtask

  task automatic t_strobe(input logic [7:0] wd);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_ofs = 3'd0; host_wdata = wd;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
    check("R8 strobe high", {7'd0, ctrl_rst}, 8'h01);
    @(negedge clk);
    check("R8 strobe one cycle", {7'd0, ctrl_rst}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    int polls;
    wr(3'd1, 8'h00); wr(3'd6, 8'h05);
    t_strobe(8'h00);
    rd(3'd2, d); check("R9 busy flag set", d, 8'h85);
    polls = 1;
    while (d[7] && polls < RST_CYCLES + 4) begin
      rd(3'd2, d); polls++;
    end
    check("R9 busy clears", d, 8'h05);
    check("R9 poll bound", 8'(polls <= RST_CYCLES), 8'h01);
    t_strobe(8'hFF);
    rd(3'd5, d); check("R8 pointer untouched", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_reset_state();
    t_load();
    t_plain();
    t_burst();
    t_wrap();
    t_ignored();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule